// File: doc/BRIEF.md
# eMMC Alternative Boot Host Sequencer

This block is the host-side controller for an eMMC alternative boot. Software arms it with an enable bit, a read-direction setting, an optional wait-for-acknowledge flag, a timeout value and a target block count. Once armed, the sequencer pulls CMD low and keeps it low for the whole operation. It can listen on DAT0 for the device's acknowledge frame, and it then counts the payload blocks that the data path reports. Every event is latched as an interrupt status bit.

A boot ends when the target block count is reached or when software drops the enable bit. At that point CMD is released and a completion flag is set. When software clears that flag, the sequencer pulses an internal soft reset for the command and data state machines and returns to idle. A timeout during the boot is not an error that stops the flow: the status bit is raised, the timer reloads and the sequencer keeps going. The clock input is the card clock, and DAT0 is sampled once per cycle.

Top module: `emmc_boot_seq`

## Requirements
- R1: A boot starts only on a clock edge where `boot_en`=1 and `dir_read`=1 and the sequencer is idle and has not already started since `boot_en` was last 0. With `dir_read`=0 the enable is ignored and `cmd_low` stays 0.
- R2: From the cycle after the start edge, `cmd_low` is 1 through the acknowledge and data phases, and it drops only when the boot ends.
- R3: With `ack_wait_en`=1 at start, a 0 on DAT0 is taken as the start bit. The next three DAT0 samples are the frame. The frame 1,0,1 sets `sts[0]` (ack received) at the edge that samples the last bit.
- R4: If no start bit is seen within `tmo_val` cycles of entering the acknowledge wait, `sts[2]` (data timeout) is set. The sequencer then moves to the data phase with `cmd_low` still 1.
- R5: In an acknowledge frame, first and second bits other than 1,0 set `sts[3]` (CRC error). A last (end) bit of 0 sets `sts[4]` (end-bit error). Either error suppresses `sts[0]`, and the sequencer proceeds to the data phase.
- R6: The wait timer loads the current `tmo_val` on entry to each wait: at start, at the end of the ack phase, after each non-final block and after each timeout. It fires on the `tmo_val`-th following edge without an event, and a value of 0 acts as 1. A data-phase timeout sets `sts[2]` and the sequencer carries on.
- R7: On the edge where the `blk_target`-th `blk_rcvd` pulse is sampled (a target of 0 acts as 1), `cmd_low` drops and `sts[1]` (boot complete) is set.
- R8: `boot_en`=0 during any active phase aborts the boot on that edge: `cmd_low` drops and `sts[1]` is set.
- R9: Status bits are sticky. A 1 in `sts_clr` clears the matching bit on the next edge, a 0 leaves it alone, and a set on the same edge wins over the clear.
- R10: After the boot ends, `soft_rst` is 1 for exactly the one cycle in which `sts[1]` reads 0, and the sequencer is then idle. It does not start again until `boot_en` has been 0.
- R11: With `ack_wait_en`=0, the first DAT0 frame before the first block is checked. A start bit followed by 1,0,1 sets `sts[3]`. Any other frame has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Boot enable; 0 aborts an active boot |
| dir_read | input | 1 | Transfer direction, 1 = read |
| ack_wait_en | input | 1 | Wait for the acknowledge frame |
| tmo_val | input | TMO_W | Wait timeout in card-clock cycles |
| blk_target | input | BLK_W | Number of blocks to receive |
| dat0 | input | 1 | Sampled DAT0 line level |
| blk_rcvd | input | 1 | One-cycle pulse per received block from the data path |
| sts_clr | input | 5 | Write-1-to-clear strobes for the status bits |
| cmd_low | output | 1 | 1 = drive CMD to 0 |
| sts | output | 5 | Status: 0 ack ok, 1 complete, 2 timeout, 3 CRC error, 4 end-bit error |
| soft_rst | output | 1 | Internal soft-reset pulse for the CMD and DAT state machines |

## Verification
The acknowledge receiver is driven with the valid frame and with a frame whose middle bits are wrong. It also gets a frame with a low end bit, and with no frame at all. Together these separate the ack-ok, CRC, end-bit and timeout outcomes. With waiting disabled, both an acknowledge-shaped frame and a data-shaped frame are sent, which shows that only the first one is flagged. Timeouts of 0, 5 and 7 cycles and targets of 0 and 2 blocks pin down the reload and count points. A per-clock reference model also checks aborts, partial clears and the soft-reset hand-off.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACKW = 3'd1,
    ST_ACKB = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } bst_t;

  localparam int NSTS   = 5;
  localparam int IX_ACK = 0;
  localparam int IX_CMP = 1;
  localparam int IX_TMO = 2;
  localparam int IX_CRC = 3;
  localparam int IX_END = 4;

  // frame bits: [2] first after start, [1] second, [0] end bit
  // returns {end_err, crc_err}
  function automatic logic [1:0] ack_judge(input logic [2:0] b);
    return {~b[0], (b[2:1] != 2'b10)};
  endfunction

  function automatic logic ack_shaped(input logic [2:0] b);
    return b == 3'b101;
  endfunction

endpackage

// File: rtl/boot_tmo_ctr.sv
module boot_tmo_ctr #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] val,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  function automatic logic [TMO_W-1:0] eff_load(input logic [TMO_W-1:0] v);
    return (v == '0) ? TMO_W'(1) : v;
  endfunction

  assign expire = run && (cnt <= TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (load)           cnt <= eff_load(val);
    else if (run && !expire) cnt <= cnt - TMO_W'(1);
  end
endmodule

// File: rtl/boot_blk_ctr.sv
module boot_blk_ctr #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [BLK_W-1:0] target,
  output logic             last
);
  logic [BLK_W-1:0] cnt;

  function automatic logic reach(input logic [BLK_W-1:0] done_n,
                                 input logic [BLK_W-1:0] tgt);
    logic [BLK_W:0] nxt, lim;
    nxt = {1'b0, done_n} + (BLK_W+1)'(1);
    lim = (tgt == '0) ? (BLK_W+1)'(1) : {1'b0, tgt};
    return nxt >= lim;
  endfunction

  assign last = reach(cnt, target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + BLK_W'(1);
  end
endmodule

// File: rtl/boot_ack_shift.sv
module boot_ack_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift,
  input  logic       din,
  output logic [2:0] bits,
  output logic       last
);
  logic [1:0] sh;
  logic [1:0] idx;

  assign bits = {sh, din};
  assign last = (idx == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (clr) begin
      sh  <= '0;
      idx <= '0;
    end else if (shift) begin
      sh  <= {sh[0], din};
      idx <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/boot_sts_reg.sv
module boot_sts_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
  import emmc_boot_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_en,
  input  logic             dir_read,
  input  logic             ack_wait_en,
  input  logic [TMO_W-1:0] tmo_val,
  input  logic [BLK_W-1:0] blk_target,
  input  logic             dat0,
  input  logic             blk_rcvd,
  input  logic [NSTS-1:0]  sts_clr,
  output logic             cmd_low,
  output logic [NSTS-1:0]  sts,
  output logic             soft_rst
);
  bst_t st, st_d;
  logic spent, sniff_on, sniff_cap;

  // named internal events
  logic active, abort, start, ack_start;
  logic tmo_run, tmo_load, tmo_exp;
  logic sh_clr, sh_shift, sh_last;
  logic [2:0] bits;
  logic [1:0] verdict;
  logic ack_done, sniff_arm, sniff_done;
  logic blk_inc, blk_last;
  logic [NSTS-1:0] set_vec;

  assign active     = (st == ST_ACKW) || (st == ST_ACKB) || (st == ST_DATA);
  assign abort      = active && !boot_en;
  assign start      = (st == ST_IDLE) && boot_en && dir_read && !spent;
  assign ack_start  = (st == ST_ACKW) && !abort && !dat0;
  assign tmo_run    = !abort && (((st == ST_ACKW) && dat0) ||
                                 ((st == ST_DATA) && !blk_rcvd));
  assign ack_done   = (st == ST_ACKB) && !abort && sh_last;
  assign sniff_arm  = (st == ST_DATA) && !abort && !blk_rcvd &&
                      sniff_on && !sniff_cap && !dat0;
  assign sniff_done = (st == ST_DATA) && !abort && !blk_rcvd &&
                      sniff_cap && sh_last;
  assign blk_inc    = (st == ST_DATA) && !abort && blk_rcvd;
  assign soft_rst   = (st == ST_DONE) && !sts[IX_CMP];
  assign cmd_low    = active;

  assign sh_clr   = soft_rst || ack_start || sniff_arm;
  assign sh_shift = ((st == ST_ACKB) && !abort) ||
                    ((st == ST_DATA) && !abort && !blk_rcvd && sniff_cap);
  assign tmo_load = start || ack_done || tmo_exp || (blk_inc && !blk_last);
  assign verdict  = ack_judge(bits);

  always_comb begin
    set_vec         = '0;
    set_vec[IX_ACK] = ack_done && (verdict == 2'b00);
    set_vec[IX_CRC] = (ack_done && verdict[0]) ||
                      (sniff_done && ack_shaped(bits));
    set_vec[IX_END] = ack_done && verdict[1];
    set_vec[IX_TMO] = tmo_exp;
    set_vec[IX_CMP] = abort || (blk_inc && blk_last);
  end

  always_comb begin
    st_d = st;
    unique case (st)
      ST_IDLE: if (start) st_d = ack_wait_en ? ST_ACKW : ST_DATA;
      ST_ACKW: if (abort) st_d = ST_DONE;
               else if (!dat0) st_d = ST_ACKB;
               else if (tmo_exp) st_d = ST_DATA;
      ST_ACKB: if (abort) st_d = ST_DONE;
               else if (sh_last) st_d = ST_DATA;
      ST_DATA: if (abort || (blk_inc && blk_last)) st_d = ST_DONE;
      ST_DONE: if (soft_rst) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      spent     <= 1'b0;
      sniff_on  <= 1'b0;
      sniff_cap <= 1'b0;
    end else begin
      st    <= st_d;
      spent <= boot_en && (spent || start);
      if (start) begin
        sniff_on  <= !ack_wait_en;
        sniff_cap <= 1'b0;
      end else if (soft_rst || blk_inc) begin
        sniff_on  <= 1'b0;
        sniff_cap <= 1'b0;
      end else if (sniff_arm) begin
        sniff_cap <= 1'b1;
      end else if (sniff_done) begin
        sniff_on  <= 1'b0;
        sniff_cap <= 1'b0;
      end
    end
  end

  boot_tmo_ctr #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(tmo_load),
    .run(tmo_run), .val(tmo_val), .expire(tmo_exp)
  );

  boot_blk_ctr #(.BLK_W(BLK_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .clr(start || soft_rst), .inc(blk_inc),
    .target(blk_target), .last(blk_last)
  );

  boot_ack_shift u_sh (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift(sh_shift),
    .din(dat0), .bits(bits), .last(sh_last)
  );

  boot_sts_reg #(.N(NSTS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(sts_clr), .q(sts)
  );

  // R1: CMD only goes low after an enabled read request
  a_r1_start_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_low) |-> $past(boot_en && dir_read));

  // R8: dropping the enable releases CMD on the next edge
  a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_low && !boot_en) |=> !cmd_low);

  // R7: CMD release always comes with the completion flag
  a_r7_release_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_low) |-> sts[IX_CMP]);

  // R10: soft reset leaves the sequencer idle with CMD released
  a_r10_softrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st == ST_IDLE) && !cmd_low);

  // R5: a good ack verdict never coincides with a frame error
  a_r5_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[IX_ACK] |-> !set_vec[IX_CRC] && !set_vec[IX_END]);

  // R4: a timeout with the enable still high keeps CMD low
  a_r4_tmo_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_exp && boot_en) |=> cmd_low);
endmodule

// File: tb/sim_emmc_boot_seq.sv
module sim_emmc_boot_seq;
  localparam int TW = 16;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_en = 0, dir_read = 0, ack_wait_en = 0, dat0 = 1, blk_rcvd = 0;
  logic [TW-1:0] tmo_val = '0;
  logic [BW-1:0] blk_target = '0;
  logic [4:0] sts_clr = '0;
  logic cmd_low, soft_rst;
  logic [4:0] sts;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  emmc_boot_seq #(.TMO_W(TW), .BLK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .dir_read(dir_read),
    .ack_wait_en(ack_wait_en), .tmo_val(tmo_val), .blk_target(blk_target),
    .dat0(dat0), .blk_rcvd(blk_rcvd), .sts_clr(sts_clr),
    .cmd_low(cmd_low), .sts(sts), .soft_rst(soft_rst)
  );

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 waiting for ack, 2 reading ack, 3 data, 4 ended
  int m_ph = 0, m_left = 0, m_blk = 0, m_sts = 0;
  bit m_spent = 0, m_sn_on = 0, m_sn_cap = 0;
  int qb[$];

  function automatic int ld(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_blk = 0; m_sts = 0;
      m_spent = 0; m_sn_on = 0; m_sn_cap = 0; qb.delete();
    end else begin
      int setm;
      bit was_spent;
      setm = 0;
      was_spent = m_spent;
      m_spent = boot_en && m_spent;
      if (m_ph >= 1 && m_ph <= 3 && !boot_en) begin
        m_ph = 4; setm |= 2;
      end else begin
        case (m_ph)
          0: if (boot_en && dir_read && !was_spent) begin
               m_spent = 1; m_blk = 0; m_left = ld(int'(tmo_val));
               m_sn_on = !ack_wait_en; m_sn_cap = 0; qb.delete();
               m_ph = ack_wait_en ? 1 : 3;
             end
          1: if (!dat0) begin m_ph = 2; qb.delete(); end
             else if (m_left <= 1) begin
               setm |= 4; m_ph = 3; m_left = ld(int'(tmo_val));
             end else m_left--;
          2: begin
               qb.push_back(int'(dat0));
               if (qb.size() == 3) begin
                 bit okm, oke;
                 okm = (qb[0] == 1 && qb[1] == 0);
                 oke = (qb[2] == 1);
                 if (okm && oke) setm |= 1;
                 if (!okm) setm |= 8;
                 if (!oke) setm |= 16;
                 m_ph = 3; m_left = ld(int'(tmo_val));
               end
             end
          3: if (blk_rcvd) begin
               m_blk++; m_sn_on = 0; m_sn_cap = 0;
               if (m_blk >= ld(int'(blk_target))) begin m_ph = 4; setm |= 2; end
               else m_left = ld(int'(tmo_val));
             end else begin
               if (m_left <= 1) begin setm |= 4; m_left = ld(int'(tmo_val)); end
               else m_left--;
               if (m_sn_on) begin
                 if (!m_sn_cap) begin
                   if (!dat0) begin m_sn_cap = 1; qb.delete(); end
                 end else begin
                   qb.push_back(int'(dat0));
                   if (qb.size() == 3) begin
                     if (qb[0] == 1 && qb[1] == 0 && qb[2] == 1) setm |= 8;
                     m_sn_on = 0; m_sn_cap = 0;
                   end
                 end
               end
             end
          4: if ((m_sts & 2) == 0) m_ph = 0;
          default: m_ph = 0;
        endcase
      end
      m_sts = (m_sts & ~int'(sts_clr)) | setm;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  string bit_tag[5] = '{"R3 ack-ok bit", "R7 complete bit", "R4 timeout bit",
                        "R5 crc bit", "R5 end-bit bit"};

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 cmd_low vs model", int'(cmd_low), (m_ph >= 1 && m_ph <= 3) ? 1 : 0);
      chk("R10 soft_rst vs model", int'(soft_rst),
          (m_ph == 4 && (m_sts & 2) == 0) ? 1 : 0);
      for (int i = 0; i < 5; i++)
        chk(bit_tag[i], int'(sts[i]), (m_sts >> i) & 1);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic frame(logic [3:0] v);
    for (int i = 3; i >= 0; i--) begin dat0 = v[i]; step(); end
    dat0 = 1'b1;
  endtask

  task automatic block();
    blk_rcvd = 1'b1; step(); blk_rcvd = 1'b0;
  endtask

  task automatic clear(logic [4:0] m);
    sts_clr = m; step(); sts_clr = '0;
  endtask

  task automatic finish_boot();
    boot_en = 1'b0; step(2); clear(5'h1f); step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R2 reset cmd_low", int'(cmd_low), 0);
    chk("R9 reset status", int'(sts), 0);

    // R1: enable without read direction is ignored
    boot_en = 1; dir_read = 0; ack_wait_en = 1; tmo_val = 20; blk_target = 2;
    step(5);
    chk("R1 no start without read", int'(cmd_low), 0);
    boot_en = 0; step(2);

    // R3/R7/R10: good ack then two blocks
    dir_read = 1; boot_en = 1; step(3);
    chk("R2 cmd low in ack wait", int'(cmd_low), 1);
    frame(4'b0101);
    chk("R3 ack ok", int'(sts), 5'b00001);
    tmo_val = 10; step(4); block(); step(3); block();
    chk("R7 released after target", int'(cmd_low), 0);
    chk("R7 complete set", int'(sts[1]), 1);
    clear(5'b00011);
    chk("R10 soft reset pulse", int'(soft_rst), 1);
    step(5);
    chk("R10 no restart while enable held", int'(cmd_low), 0);
    boot_en = 0; step(2);

    // R4/R6/R8: ack timeout, data timeouts, abort
    tmo_val = 5; boot_en = 1; step(8);
    chk("R4 ack timeout flagged", int'(sts[2]), 1);
    chk("R4 cmd still low", int'(cmd_low), 1);
    tmo_val = 7; step(3); clear(5'b00100); step(8);
    chk("R6 data timeout again", int'(sts[2]), 1);
    boot_en = 0; step();
    chk("R8 abort releases", int'(cmd_low), 0);
    chk("R8 abort completes", int'(sts[1]), 1);
    clear(5'b00100); step();
    chk("R9 partial clear keeps other", int'(sts), 5'b00010);
    clear(5'h1f); step(3);

    // R5: wrong middle bits
    tmo_val = 40; boot_en = 1; step(2); frame(4'b0111);
    chk("R5 crc on wrong ack", int'(sts), 5'b01000);
    finish_boot();

    // R5: end bit low
    boot_en = 1; step(2); frame(4'b0100);
    chk("R5 end-bit error", int'(sts), 5'b10000);
    finish_boot();

    // R11: ack disabled, ack-shaped first frame
    ack_wait_en = 0; blk_target = 1; boot_en = 1; step(2); frame(4'b0101);
    chk("R11 unexpected ack flagged", int'(sts[3]), 1);
    step(2); block();
    chk("R7 single block completes", int'(sts[1]), 1);
    finish_boot();

    // R11: ack disabled, data-shaped first frame
    boot_en = 1; step(2); frame(4'b0011); step();
    chk("R11 data frame ignored", int'(sts), 0);
    finish_boot();

    // R6/R7: zero timeout and zero target act as one
    ack_wait_en = 1; tmo_val = 0; blk_target = 0; boot_en = 1; step(2);
    chk("R6 zero timeout fires", int'(sts[2]), 1);
    block();
    chk("R7 zero target acts as one", int'(sts[1]), 1);
    finish_boot();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule